// File: doc/BRIEF.md
# Stride-and-Rewind Interleaving DMA Sequencer

This block is a multi-channel DMA engine for continuous audio playback. Software keeps the samples channel-major in memory: each audio channel has its own contiguous block of words. The transmit serializers need those samples frame-interleaved, one word per audio channel for each sample instant.

Each DMA channel serves one transmit lane. A FIFO service request from the lane starts one minor loop. In a minor loop the engine reads a run of 32-bit words and writes them to the lane's fixed data register. Between words the source address moves forward by a large signed stride, which steps to the same sample of the next audio channel. At the end of the minor loop a signed rewind brings the address back to one sample past where the loop started. The last minor loop of a major pass uses a second rewind that returns the address exactly to its base.

The engine pulses a half-pass interrupt and an end-of-pass interrupt, which software uses to swap ping-pong halves. A channel may re-arm itself at the end of a pass, so it can run with no processor involvement. All channels share one memory read port and one write strobe. Only one minor loop runs at a time, and the channels take turns in round-robin order. A per-channel throttle inserts idle cycles after every bus write.

Top module: `ilv_dma`

## Requirements
- R1: After reset, and while no channel has been loaded, `rd_en`, `wr_en`, `irq_half` and `irq_done` stay low even when `req` pulses.
- R2: Every memory read (`rd_en`) is followed in the next cycle by exactly one write (`wr_en`). That write's `wr_data` is the `rd_data` returned for that read, and no write happens without a read in the cycle before it.
- R3: Every write made for channel c goes to `cfg_dst_addr[c]`, whatever element is being moved.
- R4: Within a minor loop, each element read uses the previous element's address plus the sign-extended `cfg_elem_off[c]`.
- R5: One granted request moves exactly `cfg_minor_len[c]` elements. The writes of one minor loop are never interleaved with those of another channel.
- R6: After a minor loop that is not the last of the pass, the address following the final element's stride has `cfg_minor_adj[c]` added. After the last loop of the pass (`cfg_major_len[c]` loops), `cfg_major_adj[c]` is added instead.
- R7: `irq_half[c]` is a one-cycle pulse after minor loop number floor(`cfg_major_len[c]`/2) of each pass. `irq_done[c]` is a one-cycle pulse after the last loop of the pass. The two never pulse in the same cycle.
- R8: At the end of a pass, a channel with `cfg_relink[c]`=1 stays armed, with its loop counter reloaded and its address back at base. With `cfg_relink[c]`=0 the channel disarms, and later requests cause no read, write or interrupt until `cfg_load[c]` is pulsed again.
- R9: A request that arrives while any minor loop is in progress, including one of the same channel, is kept pending and is served after that loop ends.
- R10: When more than one channel is pending, minor loops are granted in round-robin order, so two channels with requests held high alternate loop by loop.
- R11: Consecutive element writes inside a minor loop are exactly 2 + `cfg_throttle[c]` cycles apart, and two writes are never in adjacent cycles.
- R12: All address arithmetic wraps modulo 2^32, so a pass that crosses address zero still reads the intended words and returns to base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | NCH | Per-channel pulse: take the base address, clear the loop counter and arm |
| cfg_src_base | input | NCH x AW | Source base address per channel |
| cfg_dst_addr | input | NCH x AW | Fixed destination (transmit data register) per channel |
| cfg_elem_off | input | NCH x SOFF_W | Signed source stride applied after each element |
| cfg_minor_len | input | NCH x ELEM_W | Elements per minor loop |
| cfg_major_len | input | NCH x ITER_W | Minor loops per pass |
| cfg_minor_adj | input | NCH x ADJ_W | Signed rewind after a non-final minor loop |
| cfg_major_adj | input | NCH x ADJ_W | Signed rewind after the final minor loop |
| cfg_relink | input | NCH | Re-arm at the end of a pass |
| cfg_throttle | input | NCH x THR_W | Idle cycles after each bus write |
| req | input | NCH | Service request from each transmit lane |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | AW | Memory read address |
| rd_data | input | DW | Read data, valid the cycle after `rd_en` |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write data |
| irq_half | output | NCH | Half-pass interrupt pulse per channel |
| irq_done | output | NCH | End-of-pass interrupt pulse per channel |

## Verification
The bench builds the block with its defaults: two channels, 32-bit addresses and data, 4-bit throttle. It programs the real audio layout: a stride of 128 bytes, 4-word minor loops, 32-loop passes, and rewinds of -508 and -636. This makes a full pass per channel only 128 writes long. Every write of two complete passes on both channels can therefore be checked against the address base + 4·loop + 128·element, computed in the bench, together with the interrupt positions and the round-robin alternation. A final pass with a base just below 2^32 and zero throttle reaches the address wrap, the tightest write spacing, requests latched mid-loop, and disarming without relink.

// File: rtl/ilv_dma_pkg.sv
package ilv_dma_pkg;

   // bus engine phases
   typedef enum logic [1:0] {
      ENG_IDLE = 2'd0,
      ENG_RD   = 2'd1,
      ENG_WR   = 2'd2,
      ENG_GAP  = 2'd3
   } eng_st_e;

endpackage

// File: rtl/ilv_dma_arb.sv
// Round-robin selector: the channel after the last granted one has priority.
module ilv_dma_arb #(
   parameter int NCH  = 2,
   parameter int CH_W = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NCH-1:0]  pend,
   input  logic            take,
   output logic            gnt_vld,
   output logic [CH_W-1:0] gnt_idx
);

   logic [CH_W-1:0] last_q;

   // scan from farthest to nearest so the nearest pending channel wins
   always_comb begin
      gnt_vld = 1'b0;
      gnt_idx = '0;
      for (int k = NCH; k >= 1; k--) begin
         if (pend[(int'(last_q) + k) % NCH]) begin
            gnt_vld = 1'b1;
            gnt_idx = CH_W'((int'(last_q) + k) % NCH);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    last_q <= CH_W'(NCH - 1);
      else if (take) last_q <= gnt_idx;
   end

endmodule

// File: rtl/ilv_dma_chan.sv
// Per-channel state: source pointer, loop counter, arming, pending request, interrupts.
module ilv_dma_chan #(
   parameter int AW     = 32,
   parameter int SOFF_W = 16,
   parameter int ADJ_W  = 32,
   parameter int ITER_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [AW-1:0]     base,
   input  logic [SOFF_W-1:0] elem_off,
   input  logic [ADJ_W-1:0]  minor_adj,
   input  logic [ADJ_W-1:0]  major_adj,
   input  logic [ITER_W-1:0] major_len,
   input  logic              relink,
   input  logic              req,
   input  logic              take,
   input  logic              step,
   input  logic              last_elem,
   output logic [AW-1:0]     src,
   output logic              pend,
   output logic              irq_half,
   output logic              irq_done
);

   localparam int IW1 = ITER_W + 1;

   logic              armed_q, pend_q, half_q, done_q;
   logic [AW-1:0]     src_q;
   logic [ITER_W-1:0] iter_q;

   logic              loop_end, last_iter, half_hit;
   logic [IW1-1:0]    iter_nx;
   logic [AW-1:0]     off_x, min_x, maj_x, src_step, src_nx;

   assign loop_end  = step & last_elem;
   assign iter_nx   = {1'b0, iter_q} + IW1'(1);
   assign last_iter = iter_nx >= {1'b0, major_len};
   assign half_hit  = (major_len >= ITER_W'(2)) && (iter_nx == {1'b0, (major_len >> 1)});

   // sign extension of stride and rewinds onto the address width
   assign off_x    = AW'($signed(elem_off));
   assign min_x    = AW'($signed(minor_adj));
   assign maj_x    = AW'($signed(major_adj));
   assign src_step = src_q + off_x;
   assign src_nx   = loop_end ? (src_step + (last_iter ? maj_x : min_x)) : src_step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         pend_q  <= 1'b0;
         half_q  <= 1'b0;
         done_q  <= 1'b0;
         src_q   <= '0;
         iter_q  <= '0;
      end else if (load) begin
         armed_q <= 1'b1;
         pend_q  <= 1'b0;
         half_q  <= 1'b0;
         done_q  <= 1'b0;
         src_q   <= base;
         iter_q  <= '0;
      end else begin
         half_q <= loop_end & half_hit;
         done_q <= loop_end & last_iter;
         if (step) src_q <= src_nx;
         if (loop_end) iter_q <= last_iter ? '0 : ITER_W'(iter_nx);
         if (loop_end && last_iter && !relink) begin
            armed_q <= 1'b0;
            pend_q  <= 1'b0;
         end else if (!armed_q) begin
            pend_q <= 1'b0;
         end else begin
            pend_q <= (pend_q & ~take) | req;
         end
      end
   end

   assign src      = src_q;
   assign pend     = pend_q;
   assign irq_half = half_q;
   assign irq_done = done_q;

endmodule

// File: rtl/ilv_dma_eng.sv
// Shared bus engine: runs one minor loop at a time, read then write per element.
module ilv_dma_eng
   import ilv_dma_pkg::*;
#(
   parameter int NCH         = 2,
   parameter int CH_W        = 1,
   parameter int AW          = 32,
   parameter int DW          = 32,
   parameter int ELEM_W      = 6,
   parameter int THR_W       = 4,
   parameter bit THROTTLE_EN = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         gnt_vld,
   input  logic [CH_W-1:0]              gnt_idx,
   input  logic [NCH-1:0][ELEM_W-1:0]   minor_len,
   input  logic [NCH-1:0][THR_W-1:0]    thr,
   input  logic [NCH-1:0][AW-1:0]       dst,
   input  logic [AW-1:0]                act_src,
   input  logic [DW-1:0]                rd_data,
   output logic                         take,
   output logic [CH_W-1:0]              act_idx,
   output logic                         step,
   output logic                         last_elem,
   output logic                         rd_en,
   output logic [AW-1:0]                rd_addr,
   output logic                         wr_en,
   output logic [AW-1:0]                wr_addr,
   output logic [DW-1:0]                wr_data
);

   eng_st_e           st_q;
   logic [CH_W-1:0]   act_q;
   logic [ELEM_W-1:0] left_q;
   logic [THR_W-1:0]  gap_q;
   logic              fin_q;
   logic [THR_W-1:0]  thr_act;

   generate
      if (THROTTLE_EN) begin : g_thr
         assign thr_act = thr[act_q];
      end else begin : g_nothr
         assign thr_act = '0;
      end
   endgenerate

   assign take      = (st_q == ENG_IDLE) && gnt_vld;
   assign act_idx   = act_q;
   assign rd_en     = (st_q == ENG_RD);
   assign rd_addr   = act_src;
   assign wr_en     = (st_q == ENG_WR);
   assign wr_addr   = dst[act_q];
   assign wr_data   = rd_data;
   assign step      = wr_en;
   assign last_elem = (left_q <= ELEM_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ENG_IDLE;
         act_q  <= '0;
         left_q <= '0;
         gap_q  <= '0;
         fin_q  <= 1'b0;
      end else begin
         unique case (st_q)
            ENG_IDLE: begin
               if (gnt_vld) begin
                  act_q  <= gnt_idx;
                  left_q <= minor_len[gnt_idx];
                  st_q   <= ENG_RD;
               end
            end
            ENG_RD: st_q <= ENG_WR;
            ENG_WR: begin
               left_q <= left_q - ELEM_W'(1);
               fin_q  <= last_elem;
               if (thr_act != '0) begin
                  gap_q <= thr_act;
                  st_q  <= ENG_GAP;
               end else begin
                  st_q <= last_elem ? ENG_IDLE : ENG_RD;
               end
            end
            ENG_GAP: begin
               gap_q <= gap_q - THR_W'(1);
               if (gap_q <= THR_W'(1)) st_q <= fin_q ? ENG_IDLE : ENG_RD;
            end
            default: st_q <= ENG_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ilv_dma.sv
// Top: per-channel state, round-robin selection and the shared bus engine.
module ilv_dma #(
   parameter int NCH         = 2,
   parameter int AW          = 32,
   parameter int DW          = 32,
   parameter int SOFF_W      = 16,
   parameter int ADJ_W       = 32,
   parameter int ELEM_W      = 6,
   parameter int ITER_W      = 8,
   parameter int THR_W       = 4,
   parameter bit THROTTLE_EN = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NCH-1:0]             cfg_load,
   input  logic [NCH-1:0][AW-1:0]     cfg_src_base,
   input  logic [NCH-1:0][AW-1:0]     cfg_dst_addr,
   input  logic [NCH-1:0][SOFF_W-1:0] cfg_elem_off,
   input  logic [NCH-1:0][ELEM_W-1:0] cfg_minor_len,
   input  logic [NCH-1:0][ITER_W-1:0] cfg_major_len,
   input  logic [NCH-1:0][ADJ_W-1:0]  cfg_minor_adj,
   input  logic [NCH-1:0][ADJ_W-1:0]  cfg_major_adj,
   input  logic [NCH-1:0]             cfg_relink,
   input  logic [NCH-1:0][THR_W-1:0]  cfg_throttle,
   input  logic [NCH-1:0]             req,
   output logic                       rd_en,
   output logic [AW-1:0]              rd_addr,
   input  logic [DW-1:0]              rd_data,
   output logic                       wr_en,
   output logic [AW-1:0]              wr_addr,
   output logic [DW-1:0]              wr_data,
   output logic [NCH-1:0]             irq_half,
   output logic [NCH-1:0]             irq_done
);

   localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

   generate
      if (NCH < 1)                    begin : g_bad_nch  $error("NCH must be at least 1");            end
      if (AW < 8 || AW > 64)          begin : g_bad_aw   $error("AW must be within 8..64");           end
      if (SOFF_W < 2 || SOFF_W > AW)  begin : g_bad_soff $error("SOFF_W must be within 2..AW");       end
      if (ADJ_W < 2 || ADJ_W > AW)    begin : g_bad_adj  $error("ADJ_W must be within 2..AW");        end
      if (ELEM_W < 1 || ITER_W < 2)   begin : g_bad_cnt  $error("loop counter widths are too narrow"); end
      if (THR_W < 1)                  begin : g_bad_thr  $error("THR_W must be at least 1");          end
   endgenerate

   logic [NCH-1:0]         pend;
   logic [NCH-1:0][AW-1:0] src_all;
   logic                   gnt_vld, take, step, last_elem;
   logic [CH_W-1:0]        gnt_idx, act_idx;

   ilv_dma_arb #(.NCH(NCH), .CH_W(CH_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .pend(pend), .take(take),
      .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
   );

   ilv_dma_eng #(
      .NCH(NCH), .CH_W(CH_W), .AW(AW), .DW(DW), .ELEM_W(ELEM_W),
      .THR_W(THR_W), .THROTTLE_EN(THROTTLE_EN)
   ) u_eng (
      .clk(clk), .rst_n(rst_n), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx),
      .minor_len(cfg_minor_len), .thr(cfg_throttle), .dst(cfg_dst_addr),
      .act_src(src_all[act_idx]), .rd_data(rd_data),
      .take(take), .act_idx(act_idx), .step(step), .last_elem(last_elem),
      .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data)
   );

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         logic is_act, is_gnt;
         assign is_act = (act_idx == CH_W'(c));
         assign is_gnt = (gnt_idx == CH_W'(c));

         ilv_dma_chan #(.AW(AW), .SOFF_W(SOFF_W), .ADJ_W(ADJ_W), .ITER_W(ITER_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .load(cfg_load[c]),
            .base(cfg_src_base[c]), .elem_off(cfg_elem_off[c]),
            .minor_adj(cfg_minor_adj[c]), .major_adj(cfg_major_adj[c]),
            .major_len(cfg_major_len[c]), .relink(cfg_relink[c]),
            .req(req[c]), .take(take & is_gnt),
            .step(step & is_act), .last_elem(last_elem),
            .src(src_all[c]), .pend(pend[c]),
            .irq_half(irq_half[c]), .irq_done(irq_done[c])
         );
      end
   endgenerate

endmodule

// File: rtl/ilv_dma_chk.sv
module ilv_dma_chk #(
   parameter int NCH = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic           rd_en,
   input logic           wr_en,
   input logic [NCH-1:0] irq_half,
   input logic [NCH-1:0] irq_done
);

   // R2
   rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> wr_en);

   // R2
   wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> $past(rd_en));

   // R11
   wr_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !wr_en);

   // R7
   irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) (irq_half & irq_done) == '0);

   // R7
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) (|irq_done) |=> (irq_done == '0));

   // R7
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|irq_half) || (|irq_done)) |-> $past(wr_en));

endmodule

bind ilv_dma ilv_dma_chk #(.NCH(NCH)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
   .irq_half(irq_half), .irq_done(irq_done)
);

// File: tb/tb_ilv_dma.sv
`timescale 1ns/1ps
module tb_ilv_dma;

   localparam logic [31:0] DST0 = 32'h4000_0020;
   localparam logic [31:0] DST1 = 32'h4000_0024;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        cfg_load = '0;
   logic [1:0][31:0]  cfg_src_base;
   logic [1:0][31:0]  cfg_dst_addr;
   logic [1:0][15:0]  cfg_elem_off;
   logic [1:0][5:0]   cfg_minor_len;
   logic [1:0][7:0]   cfg_major_len;
   logic [1:0][31:0]  cfg_minor_adj;
   logic [1:0][31:0]  cfg_major_adj;
   logic [1:0]        cfg_relink;
   logic [1:0][3:0]   cfg_throttle;
   logic [1:0]        req = '0;
   logic              rd_en, wr_en;
   logic [31:0]       rd_addr, wr_addr, wr_data;
   logic [31:0]       rd_data = '0;
   logic [1:0]        irq_half, irq_done;

   ilv_dma dut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_src_base(cfg_src_base),
      .cfg_dst_addr(cfg_dst_addr), .cfg_elem_off(cfg_elem_off),
      .cfg_minor_len(cfg_minor_len), .cfg_major_len(cfg_major_len),
      .cfg_minor_adj(cfg_minor_adj), .cfg_major_adj(cfg_major_adj),
      .cfg_relink(cfg_relink), .cfg_throttle(cfg_throttle), .req(req),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .irq_half(irq_half), .irq_done(irq_done)
   );

   always #5 clk = ~clk;

   function automatic logic [31:0] memf(input logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ 32'h0000_5A5A;
   endfunction

   // memory model: data returns the cycle after the read strobe
   always @(posedge clk) if (rd_en) rd_data <= memf(rd_addr);

   int total = 0, bad = 0;
   int cyc = 0;
   int cnt[2], start[2], thr_exp[2], nh[2], nd[2];
   logic [31:0] bbase[2];
   int n_rd = 0, quiet = 0, last_ch = -1, run = 0, last_loop_ch = -1, last_wr_cyc = 0;
   bit rr_on = 0, ph4 = 0, idle_chk = 0;
   logic [31:0] rd_addr_q = '0;
   int ch, k, ii, ee;
   logic [31:0] exp_a;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, expv, $time);
      end
   endtask

   always @(posedge clk) cyc++;

   // output monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (idle_chk) begin
            chk(!rd_en && !wr_en && irq_half == 0 && irq_done == 0, "R1 idle outputs",
                {28'd0, irq_done, irq_half} | {rd_en, wr_en, 30'd0}, 32'd0);
         end
         if (rd_en || wr_en) quiet = 0; else quiet++;
         if (rd_en) begin
            rd_addr_q = rd_addr;
            n_rd++;
         end
         if (wr_en) begin
            ch = (wr_addr == DST0) ? 0 : (wr_addr == DST1) ? 1 : -1;
            chk(ch >= 0, "R3 destination", wr_addr, DST0);
            if (ch >= 0) begin
               k = cnt[ch] - start[ch];
               ii = (k / 4) % 32;
               ee = k % 4;
               exp_a = bbase[ch] + 32'(4 * ii + 128 * ee);
               chk(rd_addr_q == exp_a, ph4 ? "R12 wrapped address" :
                   (ee == 0 && k > 0) ? "R6 rewind address" : "R4 stride address", rd_addr_q, exp_a);
               chk(wr_data == memf(exp_a), "R2 write data", wr_data, memf(exp_a));
               if (last_ch >= 0 && ch != last_ch)
                  chk(run % 4 == 0, "R5 minor loop interleaved", 32'(run), 32'd4);
               run = (ch == last_ch) ? run + 1 : 1;
               last_ch = ch;
               if (rr_on && ee == 0 && last_loop_ch >= 0)
                  chk(ch != last_loop_ch, "R10 round robin", 32'(ch), 32'(1 - last_loop_ch));
               if (ee == 0) last_loop_ch = ch;
               if (ee != 0)
                  chk(cyc - last_wr_cyc == 2 + thr_exp[ch], "R11 throttle spacing",
                      32'(cyc - last_wr_cyc), 32'(2 + thr_exp[ch]));
               last_wr_cyc = cyc;
               cnt[ch]++;
            end
         end
         for (int c = 0; c < 2; c++) begin
            if (irq_half[c]) begin
               nh[c]++;
               chk((cnt[c] - start[c]) % 128 == 64, "R7 half interrupt position",
                   32'((cnt[c] - start[c]) % 128), 32'd64);
            end
            if (irq_done[c]) begin
               nd[c]++;
               chk((cnt[c] - start[c]) % 128 == 0 && cnt[c] > start[c], "R7 done interrupt position",
                   32'((cnt[c] - start[c]) % 128), 32'd0);
            end
         end
      end
   end

   task automatic pulse_req(input int c);
      @(negedge clk) req[c] = 1'b1;
      @(negedge clk) req[c] = 1'b0;
   endtask

   task automatic run_all();
      int s_rd, s_c0, s_c1, s_h, s_d;
      // reset state
      repeat (3) @(negedge clk);
      chk(!rd_en && !wr_en && irq_half == 0 && irq_done == 0, "R1 reset outputs",
          {rd_en, wr_en, 26'd0, irq_done, irq_half}, 32'd0);
      @(negedge clk) rst_n = 1'b1;
      idle_chk = 1;
      for (int p = 0; p < 4; p++) begin
         pulse_req(0);
         pulse_req(1);
      end
      repeat (5) @(negedge clk);
      idle_chk = 0;

      // phase A: audio layout, both channels relinking, requests held high
      for (int c = 0; c < 2; c++) begin
         cfg_elem_off[c]  = 16'd128;
         cfg_minor_len[c] = 6'd4;
         cfg_major_len[c] = 8'd32;
         cfg_minor_adj[c] = -32'sd508;
         cfg_major_adj[c] = -32'sd636;
         cfg_relink[c]    = 1'b1;
      end
      cfg_src_base[0] = 32'h0000_1000; bbase[0] = 32'h0000_1000;
      cfg_src_base[1] = 32'h0000_1200; bbase[1] = 32'h0000_1200;
      cfg_dst_addr[0] = DST0;
      cfg_dst_addr[1] = DST1;
      cfg_throttle[0] = 4'd3; thr_exp[0] = 3;
      cfg_throttle[1] = 4'd5; thr_exp[1] = 5;
      @(negedge clk) cfg_load = 2'b11;
      @(negedge clk) begin cfg_load = 2'b00; rr_on = 1; req = 2'b11; end
      while (cnt[0] < 256 || cnt[1] < 256) @(negedge clk);

      // phase B: drop relink, channels stop at their pass end
      rr_on = 0;
      cfg_relink = 2'b00;
      while (quiet < 200) @(negedge clk);
      req = 2'b00;
      chk(cnt[0] % 128 == 0, "R8 stop at pass end ch0", 32'(cnt[0]), 32'(cnt[0] / 128 * 128));
      chk(cnt[1] % 128 == 0, "R8 stop at pass end ch1", 32'(cnt[1]), 32'(cnt[1] / 128 * 128));
      chk(nh[0] == cnt[0] / 128, "R7 half count ch0", 32'(nh[0]), 32'(cnt[0] / 128));
      chk(nd[1] == cnt[1] / 128, "R7 done count ch1", 32'(nd[1]), 32'(cnt[1] / 128));
      s_rd = n_rd; s_c0 = cnt[0]; s_c1 = cnt[1]; s_h = nh[0] + nh[1]; s_d = nd[0] + nd[1];
      for (int p = 0; p < 10; p++) begin
         pulse_req(0);
         pulse_req(1);
      end
      repeat (50) @(negedge clk);
      chk(n_rd == s_rd, "R8 disarmed reads", 32'(n_rd), 32'(s_rd));
      chk(cnt[0] == s_c0 && cnt[1] == s_c1, "R8 disarmed writes", 32'(cnt[0] + cnt[1]), 32'(s_c0 + s_c1));
      chk(nh[0] + nh[1] == s_h && nd[0] + nd[1] == s_d, "R8 disarmed interrupts",
          32'(nh[0] + nh[1] + nd[0] + nd[1]), 32'(s_h + s_d));

      // phase C: base below the wrap point, no throttle, single-shot pass
      ph4 = 1;
      cfg_src_base[0] = 32'hFFFF_FF80; bbase[0] = 32'hFFFF_FF80;
      cfg_throttle[0] = 4'd0; thr_exp[0] = 0;
      start[0] = cnt[0];
      s_d = nd[0];
      @(negedge clk) cfg_load = 2'b01;
      @(negedge clk) cfg_load = 2'b00;
      pulse_req(0);
      while (cnt[0] == start[0]) @(negedge clk);
      pulse_req(0);
      repeat (60) @(negedge clk);
      chk(cnt[0] - start[0] == 8, "R9 request latched mid-loop", 32'(cnt[0] - start[0]), 32'd8);
      while (cnt[0] - start[0] < 128) begin
         pulse_req(0);
         repeat (10) @(negedge clk);
      end
      repeat (60) @(negedge clk);
      chk(cnt[0] - start[0] == 128, "R8 single pass length", 32'(cnt[0] - start[0]), 32'd128);
      chk(nd[0] == s_d + 1, "R7 done after wrapped pass", 32'(nd[0]), 32'(s_d + 1));
   endtask

   initial begin
      for (int c = 0; c < 2; c++) begin
         cnt[c] = 0; start[c] = 0; nh[c] = 0; nd[c] = 0; thr_exp[c] = 0; bbase[c] = '0;
      end
      cfg_src_base = '0; cfg_dst_addr = '0; cfg_elem_off = '0; cfg_minor_len = '0;
      cfg_major_len = '0; cfg_minor_adj = '0; cfg_major_adj = '0; cfg_relink = '0;
      cfg_throttle = '0;
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
         end
      join_any
      disable fork;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule